// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one accepted burst request into the column addresses of that burst, one per beat. A mode word sets the burst length and the ordering. When a start strobe arrives and no burst is running, the block captures the starting column. It then presents one column address per beat on a valid/ready output handshake and marks the final beat.

All addresses of a burst stay inside an aligned block whose size is the burst length. The column bits above that block's offset field never change during the burst. The low offset bits start at the requested position and wrap at the block edge. In sequential ordering the offset counts upward modulo the burst length. In interleaved ordering the offset is the starting position XOR the beat number.

A reserved length code in the mode word blocks the start and raises an error flag. A command sequencer uses the block by setting the mode word, pulsing the start strobe with the column from a read or write command, and draining the beats as its data path can accept them.

Top module: `burst_col_gen`

## Requirements
- R1: Mode bits [2:0] select the burst length: code 1 gives 2 beats, code 2 gives 4 beats and code 3 gives 8 beats. The same length applies to every burst.
- R2: When mode bit 3 is 0 (sequential), beat k carries the offset (s + k) mod BL, where s is the starting offset given by the low log2(BL) bits of the start column.
- R3: When mode bit 3 is 1 (interleaved), beat k carries the offset s XOR k.
- R4: Every beat keeps the start column's bits above the low log2(BL) bits.
- R5: A start accepted at a clock edge presents beat 0 (equal to the start column) on the following cycle. Each beat advances only on a cycle with valid and ready both high. While ready is low, the address and last flag hold.
- R6: The last flag is high exactly on beat BL-1. After that beat is taken, valid is low on the next cycle.
- R7: A start while idle with a reserved length code (0, 4, 5, 6 or 7) begins no burst and sets the error flag on the next cycle. The next start with a legal code clears it.
- R8: A start strobe while a burst is active is ignored. The running sequence continues unchanged, and no further burst follows it.
- R9: After reset, valid, last and the error flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeWord | input | 4 | [2:0] length code, [3] ordering (1 = interleaved) |
| startValid | input | 1 | Start request, sampled while idle |
| startCol | input | COL_W | Starting column of the burst |
| colReady | input | 1 | Consumer accepts the current beat |
| colValid | output | 1 | A beat address is presented |
| colAddr | output | COL_W | Column address of the current beat |
| colLast | output | 1 | Current beat is the final one |
| modeErr | output | 1 | Last start attempt used a reserved length code |

## Verification
The hardest case to reach is a start strobe that lands in the middle of a running burst, especially while the consumer is stalling. The bench raises the start strobe with a different column during a chosen beat of a burst. It then confirms that the remaining addresses still follow the first request and that valid stays low after the last beat. A sweep over all eight length codes, both orderings and every low-bit start position, with alternate bursts stalling every beat, covers each wrap point and each hold.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  // Widest burst is 8 beats, so the in-block offset is at most 3 bits.
  localparam int OFS_W = 3;
  localparam int LEN_CODE_W = 3;

  typedef struct packed {
    logic             capture;  // latch start column and ordering
    logic [OFS_W-1:0] beat;     // current beat index
  } strobes_t;

  function automatic logic lenLegal(input logic [LEN_CODE_W-1:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
  endfunction

  // Offset mask, which is also the last beat index (BL-1).
  function automatic logic [OFS_W-1:0] lenMask(input logic [LEN_CODE_W-1:0] code);
    logic [OFS_W-1:0] m;
    case (code)
      3'd1:    m = 3'd1;
      3'd2:    m = 3'd3;
      3'd3:    m = 3'd7;
      default: m = 3'd0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_col_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  startValid,
  input  logic                  colReady,
  output logic                  colValid,
  output logic                  colLast,
  output logic                  modeErr,
  output strobes_t              strobes
);
  logic             active;
  logic [OFS_W-1:0] beatIdx;
  logic [OFS_W-1:0] lastIdx;
  logic             errQ;
  logic             accept;
  logic             legal;
  logic             atLast;

  assign accept = startValid && !active;
  assign legal  = lenLegal(lenCode);
  assign atLast = (beatIdx == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      beatIdx <= '0;
      lastIdx <= '0;
      errQ    <= 1'b0;
    end else if (accept) begin
      errQ <= !legal;
      if (legal) begin
        active  <= 1'b1;
        beatIdx <= '0;
        lastIdx <= lenMask(lenCode);
      end
    end else if (active && colReady) begin
      if (atLast) begin
        active <= 1'b0;
      end else begin
        beatIdx <= beatIdx + 1'b1;
      end
    end
  end

  assign colValid        = active;
  assign colLast         = active && atLast;
  assign modeErr         = errQ;
  assign strobes.capture = accept && legal;
  assign strobes.beat    = beatIdx;
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  orderBit,
  input  logic [COL_W-1:0]      startCol,
  input  strobes_t              strobes,
  output logic [COL_W-1:0]      colAddr
);
  localparam int HI_W = COL_W - OFS_W;

  logic [COL_W-1:0] baseCol;
  logic             interleave;
  logic [OFS_W-1:0] mask;
  logic [OFS_W-1:0] startOfs;
  logic [OFS_W-1:0] seqOfs;
  logic [OFS_W-1:0] xorOfs;
  logic [OFS_W-1:0] beatOfs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol    <= '0;
      interleave <= 1'b0;
      mask       <= '0;
    end else if (strobes.capture) begin
      baseCol    <= startCol;
      interleave <= orderBit;
      mask       <= lenMask(lenCode);
    end
  end

  assign startOfs = baseCol[OFS_W-1:0];
  assign seqOfs   = (startOfs + strobes.beat) & mask;
  assign xorOfs   = (startOfs ^ strobes.beat) & mask;
  assign beatOfs  = interleave ? xorOfs : seqOfs;

  generate
    if (HI_W > 0) begin : g_hi
      assign colAddr = {baseCol[COL_W-1:OFS_W], (startOfs & ~mask) | beatOfs};
    end else begin : g_nohi
      assign colAddr = (startOfs & ~mask) | beatOfs;
    end
  endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       modeWord,
  input  logic             startValid,
  input  logic [COL_W-1:0] startCol,
  input  logic             colReady,
  output logic             colValid,
  output logic [COL_W-1:0] colAddr,
  output logic             colLast,
  output logic             modeErr
);
  strobes_t strobes;

  burst_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lenCode    (modeWord[2:0]),
    .startValid (startValid),
    .colReady   (colReady),
    .colValid   (colValid),
    .colLast    (colLast),
    .modeErr    (modeErr),
    .strobes    (strobes)
  );

  burst_dp #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lenCode  (modeWord[2:0]),
    .orderBit (modeWord[3]),
    .startCol (startCol),
    .strobes  (strobes),
    .colAddr  (colAddr)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       modeWord,
  input logic             startValid,
  input logic [COL_W-1:0] startCol,
  input logic             colReady,
  input logic             colValid,
  input logic [COL_W-1:0] colAddr,
  input logic             colLast,
  input logic             modeErr
);
  logic reservedCode;
  assign reservedCode = !(modeWord[2:0] == 3'd1 || modeWord[2:0] == 3'd2 ||
                          modeWord[2:0] == 3'd3);

  p_reserved_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !colValid && reservedCode) |=> (!colValid && modeErr));

  p_first_beat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !colValid && !reservedCode) |=> (colValid && colAddr == $past(startCol) && !modeErr));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && !colReady) |=> (colValid && $stable(colAddr) && $stable(colLast)));

  p_block_fixed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && colReady && !colLast) |=> (colValid && colAddr[COL_W-1:3] == $past(colAddr[COL_W-1:3])));

  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && colReady && colLast) |=> !colValid);

  p_last_qualified_r6: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [3:0]       modeWord = '0;
  logic             startValid = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic             colReady = 1'b0;
  logic             colValid;
  logic [COL_W-1:0] colAddr;
  logic             colLast;
  logic             modeErr;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 1'b0;

  burst_col_gen #(.COL_W(COL_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expAddr(input int code, input int ord, input int col, input int k);
    int bl = 1 << code;
    int s  = col & (bl - 1);
    int off = ord ? ((s ^ k) & (bl - 1)) : ((s + k) % bl);
    return (col & ~(bl - 1)) | off;
  endfunction

  // Inputs change at the falling edge, outputs are checked there too.
  task automatic runBurst(input int code, input int ord, input int col, input bit stall,
                          input int intrudeBeat);
    modeWord   = {ord[0], code[2:0]};
    startCol   = col[COL_W-1:0];
    startValid = 1'b1;
    colReady   = 1'b0;
    @(negedge clk);
    startValid = 1'b0;
    if (code < 1 || code > 3) begin
      check("R7", "valid after reserved start", colValid, 0);
      check("R7", "error flag", modeErr, 1);
      return;
    end
    check("R7", "error flag cleared", modeErr, 0);
    for (int k = 0; k < (1 << code); k++) begin
      if (k == intrudeBeat) begin
        startValid = 1'b1;
        startCol   = ~col[COL_W-1:0];
      end
      if (stall) begin
        colReady = 1'b0;
        check("R5", "valid while stalled", colValid, 1);
        check(ord ? "R3" : "R2", "addr before stall", colAddr, expAddr(code, ord, col, k));
        @(negedge clk);
        check("R5", "addr held in stall", colAddr, expAddr(code, ord, col, k));
      end
      colReady = 1'b1;
      check("R5", "valid", colValid, 1);
      check(ord ? "R3" : "R2", "beat addr", colAddr, expAddr(code, ord, col, k));
      check("R4", "block bits", colAddr >> code, col >> code);
      check("R6", "last flag", colLast, (k == (1 << code) - 1) ? 1 : 0);
      @(negedge clk);
      startValid = 1'b0;
    end
    colReady = 1'b0;
    check("R6", "valid after last", colValid, 0);
    if (intrudeBeat >= 0) begin
      @(negedge clk);
      check("R8", "no burst from ignored start", colValid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "valid at reset", colValid, 0);
    check("R9", "last at reset", colLast, 0);
    check("R9", "error at reset", modeErr, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "valid after reset", colValid, 0);
    // R1 R2 R3: sweep all codes, both orderings, all low start positions.
    for (int code = 0; code < 8; code++)
      for (int ord = 0; ord < 2; ord++)
        for (int lo = 0; lo < 16; lo++)
          for (int st = 0; st < 2; st++)
            runBurst(code, ord, (lo * 37 + 'h250) & 'h3ff | lo, st[0], -1);
    // R7: reserved code then legal code clears the flag.
    runBurst(5, 0, 'h123, 1'b0, -1);
    runBurst(2, 1, 'h1f6, 1'b0, -1);
    // R8: start strobes raised during active bursts, stalled and not.
    runBurst(3, 0, 'h2a5, 1'b0, 3);
    runBurst(3, 1, 'h0d3, 1'b1, 5);
    runBurst(1, 0, 'h3ff, 1'b1, 1);
    runBurst(2, 1, 'h10e, 1'b0, 0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        errCount++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule